// File: doc/BRIEF.md
# Full-Stop Entry and Wake Controller

This block decides when a processor may drop into its deepest low-power state, with every clock including the oscillator switched off, and how it comes back out. A one-cycle stop strobe from the core enters the stopped state only when the stop-disable flag is clear. When that flag is set, the strobe does nothing and the core carries on. While the block is stopped, its wake detection is pure logic, so an active-low level on the reset, non-maskable or maskable interrupt pin turns the oscillator enable back on without any clock edge. A pending edge on the maskable interrupt does the same. The maskable interrupt counts only while its mask flag is clear.

Once the clocks run again, a stabilization timer waits for the oscillator to settle. The block then issues a single-cycle wake pulse carrying a 2-bit action code for the core's sequencer: resume at the next instruction, service the non-maskable interrupt, service the maskable interrupt, or run the reset sequence. When the non-maskable interrupt wakes the part while its mask flag is set, the block wakes without servicing it and the core resumes inline. The block also gates four peripheral clocks in the lighter wait mode. Each peripheral keeps its clock only while its own enable bit is set.

Top module: `stop_wake_ctrl`

## Requirements
- R1: A stop strobe while `s_flag` is 1 has no effect: `stop_active` stays 0, `osc_en` stays 1 and no wake pulse follows.
- R2: A stop strobe while running with `s_flag` at 0 sets `stop_active` after the next clock edge. While stopped with no wake source present, `osc_en` and all four `clk_gate` bits are 0.
- R3: While stopped, `osc_en` returns to 1 in the same cycle, with no clock edge needed, when any of these is true: `reset_n` is low, `xirq_n` is low, or `i_mask` is 0 and either `irq_n` is low or `irq_edge_pend` is 1.
- R4: While stopped with `i_mask` at 1, a low `irq_n` and `irq_edge_pend` are both ignored: `osc_en` stays 0 and `stop_active` stays 1.
- R5: A low `xirq_n` wakes the part whatever the value of `x_mask`.
- R6: `wake_valid` is high for exactly one cycle. It rises on the L-th clock edge after the edge that leaves the stopped state. L is the larger of STAB_CYCLES and 3, or L is 3 when STAB_BYPASS is 1.
- R7: `wake_code` encoding: 2'b00 resume at next instruction, 2'b01 service XIRQ, 2'b10 service IRQ, 2'b11 run reset sequence. An XIRQ wake gives 01 when `x_mask` is 0 and 00 when `x_mask` is 1.
- R8: When several sources are active, reset wins over XIRQ and XIRQ wins over IRQ when choosing `wake_code`.
- R9: An IRQ wake, whether from a low `irq_n` or from `irq_edge_pend`, with `i_mask` 0 and no other source, gives code 2'b10.
- R10: While running, `clk_gate` follows the settings one edge later. With `wait_mode` 0, every bit is 1. With `wait_mode` 1, bit k equals `periph_en[k]`. The bit order is 0 A/D, 1 SPI, 2 serial transmit, 3 serial receive.
- R11: After a synchronous `rst`: `stop_active` is 0, `wake_valid` is 0, `osc_en` is 1 and `clk_gate` is all ones. After a wake pulse, `stop_active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset of the controller |
| stop_req | input | 1 | One-cycle stop instruction strobe |
| s_flag | input | 1 | Stop-disable flag |
| i_mask | input | 1 | Maskable interrupt mask flag |
| x_mask | input | 1 | Non-maskable interrupt mask flag |
| irq_n | input | 1 | Maskable interrupt pin, active low, asynchronous |
| xirq_n | input | 1 | Non-maskable interrupt pin, active low, asynchronous |
| reset_n | input | 1 | External reset pin, active low, asynchronous |
| irq_edge_pend | input | 1 | Edge-triggered IRQ request pending |
| wait_mode | input | 1 | Core is in wait mode |
| periph_en | input | 4 | Peripheral enables: A/D, SPI, serial tx, serial rx |
| osc_en | output | 1 | Global oscillator and clock enable |
| stop_active | output | 1 | Block is in the stopped state |
| wake_valid | output | 1 | One-cycle wake action strobe |
| wake_code | output | 2 | Wake action code |
| clk_gate | output | 4 | Per-peripheral clock enables |

## Verification
On every cycle, the assertions check four things: the no-op treatment of a disabled stop, the masking of IRQ while stopped, the single-cycle width of the wake pulse, and the frozen peripheral gates while the oscillator is off. The wake pulse is also checked to come only out of the stabilization phase. The code priority, the XIRQ mask turning service into an inline resume, the settling latency, and the combinational oscillator restart with no clock edge can be shown only by the bench scenarios. Those scenarios drive pin combinations into a stopped block and time the resulting pulse.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {ST_RUN = 2'd0, ST_STOP = 2'd1, ST_STAB = 2'd2} swc_state_e;
  typedef enum logic [1:0] {
    WK_RESUME = 2'b00,
    WK_XIRQ   = 2'b01,
    WK_IRQ    = 2'b10,
    WK_RESET  = 2'b11
  } wake_code_e;
  localparam int NUM_PERIPH = 4;
  localparam int NUM_PINS   = 3;
  localparam int MIN_STAB   = 3;
endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '1;
        else if (s == 0) chain[s] <= d_async;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/swc_wake_detect.sv
module swc_wake_detect (
  input  logic irq_n,
  input  logic xirq_n,
  input  logic reset_n,
  input  logic irq_edge_pend,
  input  logic i_mask,
  output logic wake_det
);
  logic irq_live;
  always_comb begin
    irq_live = !i_mask && (!irq_n || irq_edge_pend);
    wake_det = !reset_n || !xirq_n || irq_live;
  end
endmodule

// File: rtl/swc_stab_timer.sv
module swc_stab_timer #(
  parameter int LEN = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic done
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] START = CW'(LEN - 1);

  logic [CW-1:0] cnt;
  logic          running;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (load) begin
      cnt     <= START;
      running <= 1'b1;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else cnt <= cnt - 1'b1;
    end
  end

  assign done = running && (cnt == '0);

  // R6
  timer_bound_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/swc_periph_gate.sv
module swc_periph_gate #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wait_mode,
  input  logic [N-1:0] periph_en,
  input  logic         osc_en,
  output logic [N-1:0] clk_gate
);
  logic [N-1:0] gate_q;

  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_periph
      always_ff @(posedge clk) begin
        if (rst) gate_q[k] <= 1'b1;
        else gate_q[k] <= !wait_mode || periph_en[k];
      end
      assign clk_gate[k] = gate_q[k] && osc_en;
    end
  endgenerate

  // R2
  gate_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> (clk_gate == '0));
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import swc_pkg::*;
#(
  parameter int STAB_CYCLES = 4096,
  parameter bit STAB_BYPASS = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  stop_req,
  input  logic                  s_flag,
  input  logic                  i_mask,
  input  logic                  x_mask,
  input  logic                  irq_n,
  input  logic                  xirq_n,
  input  logic                  reset_n,
  input  logic                  irq_edge_pend,
  input  logic                  wait_mode,
  input  logic [NUM_PERIPH-1:0] periph_en,
  output logic                  osc_en,
  output logic                  stop_active,
  output logic                  wake_valid,
  output logic [1:0]            wake_code
  ,output logic [NUM_PERIPH-1:0] clk_gate
);
  localparam int FLOOR    = (SYNC_STAGES + 1 > MIN_STAB) ? SYNC_STAGES + 1 : MIN_STAB;
  localparam int STAB_LEN = STAB_BYPASS ? FLOOR :
                            ((STAB_CYCLES > FLOOR) ? STAB_CYCLES : FLOOR);

  swc_state_e state;
  logic       wake_det;
  logic       tmr_load, tmr_done;
  logic [NUM_PINS-1:0] pins_s;
  logic [NUM_PINS-1:0] cause_now, cause_acc, cause_all;
  wake_code_e pick;

  swc_wake_detect u_det (
    .irq_n(irq_n), .xirq_n(xirq_n), .reset_n(reset_n),
    .irq_edge_pend(irq_edge_pend), .i_mask(i_mask), .wake_det(wake_det)
  );

  swc_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async({reset_n, xirq_n, irq_n}), .q_sync(pins_s)
  );

  assign tmr_load = (state == ST_STOP) && wake_det;

  swc_stab_timer #(.LEN(STAB_LEN)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .done(tmr_done)
  );

  // bit 2 reset, bit 1 xirq, bit 0 irq
  always_comb begin
    cause_now[2] = !pins_s[2];
    cause_now[1] = !pins_s[1];
    cause_now[0] = !i_mask && (!pins_s[0] || irq_edge_pend);
    cause_all    = cause_now | cause_acc;
    if (cause_all[2])      pick = WK_RESET;
    else if (cause_all[1]) pick = x_mask ? WK_RESUME : WK_XIRQ;
    else if (cause_all[0]) pick = WK_IRQ;
    else                   pick = WK_RESUME;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_RUN;
      wake_valid <= 1'b0;
      wake_code  <= WK_RESUME;
      cause_acc  <= '0;
    end else begin
      wake_valid <= 1'b0;
      unique case (state)
        ST_RUN: begin
          if (stop_req && !s_flag) state <= ST_STOP;
        end
        ST_STOP: begin
          cause_acc <= '0;
          if (wake_det) state <= ST_STAB;
        end
        ST_STAB: begin
          cause_acc <= cause_all;
          if (tmr_done) begin
            state      <= ST_RUN;
            wake_valid <= 1'b1;
            wake_code  <= pick;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign stop_active = (state == ST_STOP);
  assign osc_en      = (state != ST_STOP) || wake_det;

  swc_periph_gate #(.N(NUM_PERIPH)) u_gate (
    .clk(clk), .rst(rst), .wait_mode(wait_mode), .periph_en(periph_en),
    .osc_en(osc_en), .clk_gate(clk_gate)
  );

  // R1
  stop_noop_chk: assert property (@(posedge clk) disable iff (rst)
    (!stop_active && stop_req && s_flag && !wake_valid && state == ST_RUN) |=> !stop_active);

  // R4
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_active && i_mask && reset_n && xirq_n) |-> !osc_en);

  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    wake_valid |=> !wake_valid);

  // R6
  pulse_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_valid) |-> !stop_active);

  // R11
  leave_run_chk: assert property (@(posedge clk) disable iff (rst)
    wake_valid |-> !stop_active);
endmodule

// File: tb/stop_wake_ctrl_bench.sv
module stop_wake_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_req = 0, s_flag = 0, i_mask = 1, x_mask = 1;
  logic irq_n = 1, xirq_n = 1, reset_n = 1, irq_edge_pend = 0, wait_mode = 0;
  logic [3:0] periph_en = 4'h0;
  logic osc_en, stop_active, wake_valid;
  logic [1:0] wake_code;
  logic [3:0] clk_gate;
  logic b_osc, b_stop, b_valid;
  logic [1:0] b_code;
  logic [3:0] b_gate;
  int total = 0, bad = 0, cyc = 0;

  always #4 clk = ~clk;

  stop_wake_ctrl #(.STAB_CYCLES(8)) u_stop_wake_ctrl (
    .clk(clk), .rst(rst), .stop_req(stop_req), .s_flag(s_flag), .i_mask(i_mask),
    .x_mask(x_mask), .irq_n(irq_n), .xirq_n(xirq_n), .reset_n(reset_n),
    .irq_edge_pend(irq_edge_pend), .wait_mode(wait_mode), .periph_en(periph_en),
    .osc_en(osc_en), .stop_active(stop_active), .wake_valid(wake_valid),
    .wake_code(wake_code), .clk_gate(clk_gate));

  stop_wake_ctrl #(.STAB_CYCLES(8), .STAB_BYPASS(1'b1)) u_stop_wake_ctrl_byp (
    .clk(clk), .rst(rst), .stop_req(stop_req), .s_flag(s_flag), .i_mask(i_mask),
    .x_mask(x_mask), .irq_n(irq_n), .xirq_n(xirq_n), .reset_n(reset_n),
    .irq_edge_pend(irq_edge_pend), .wait_mode(wait_mode), .periph_en(periph_en),
    .osc_en(b_osc), .stop_active(b_stop), .wake_valid(b_valid),
    .wake_code(b_code), .clk_gate(b_gate));

  // {i_mask, x_mask, irq_n, xirq_n, reset_n, edge, code[1:0]}
  localparam logic [7:0] VEC [8] = '{
    8'b10101001, 8'b11101000, 8'b00011010, 8'b00111110,
    8'b10110011, 8'b10100011, 8'b00001001, 8'b01001000
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic enter_stop();
    @(negedge clk); stop_req = 1;
    @(negedge clk); stop_req = 0;
  endtask

  task automatic release_pins();
    @(negedge clk);
    irq_n = 1; xirq_n = 1; reset_n = 1; irq_edge_pend = 0;
    repeat (4) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, nb, code_m, code_b;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    check(stop_active == 0 && wake_valid == 0, "R11 reset status", stop_active, 0);
    check(osc_en == 1 && clk_gate == 4'hF, "R11 reset osc/gates", clk_gate, 15);

    // R1 disabled stop
    s_flag = 1;
    enter_stop();
    n = 0;
    repeat (12) begin @(negedge clk); if (stop_active || !osc_en || wake_valid) n++; end
    check(n == 0, "R1 stop with S set", n, 0);
    s_flag = 0;

    // vector table: R2 R3 R5 R6 R7 R8 R9
    for (int v = 0; v < 8; v++) begin
      i_mask = VEC[v][7]; x_mask = VEC[v][6];
      enter_stop();
      check(stop_active == 1 && osc_en == 0 && clk_gate == 4'h0, "R2 stopped", osc_en, 0);
      irq_n = VEC[v][5]; xirq_n = VEC[v][4]; reset_n = VEC[v][3]; irq_edge_pend = VEC[v][2];
      #1;
      check(osc_en == 1, "R3 combinational wake", osc_en, 1);
      n = 0; nb = 0; code_m = -1; code_b = -1;
      for (int k = 1; k <= 20; k++) begin
        @(negedge clk);
        if (b_valid && nb == 0) begin nb = k; code_b = b_code; end
        if (wake_valid && n == 0) begin n = k; code_m = wake_code; end
      end
      check(n == 9, "R6 settle latency", n, 9);
      check(nb == 4, "R6 bypass latency", nb, 4);
      check(code_m == int'(VEC[v][1:0]), "R7 R8 R9 wake code", code_m, VEC[v][1:0]);
      check(code_b == int'(VEC[v][1:0]), "R7 bypass wake code", code_b, VEC[v][1:0]);
      check(stop_active == 0, "R11 running after wake", stop_active, 0);
      release_pins();
    end

    // R6 single-cycle pulse
    x_mask = 0; i_mask = 1;
    enter_stop();
    xirq_n = 0;
    n = 0;
    repeat (20) begin @(negedge clk); if (wake_valid) n++; end
    check(n == 1, "R6 pulse width", n, 1);
    check(wake_code == 2'b01, "R5 R7 xirq service", wake_code, 1);
    release_pins();

    // R4 masked IRQ ignored, then R5 XIRQ with X set resumes
    i_mask = 1; x_mask = 1;
    enter_stop();
    irq_n = 0; irq_edge_pend = 1;
    repeat (6) @(negedge clk);
    check(osc_en == 0 && stop_active == 1 && clk_gate == 4'h0, "R4 masked irq", osc_en, 0);
    xirq_n = 0;
    n = 0; code_m = -1;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (wake_valid && n == 0) begin n = k; code_m = wake_code; end
    end
    check(code_m == 0, "R5 masked xirq resumes", code_m, 0);
    release_pins();

    // R10 wait-mode gating
    wait_mode = 0; periph_en = 4'b0000;
    @(negedge clk);
    check(clk_gate == 4'hF, "R10 no wait", clk_gate, 15);
    wait_mode = 1; periph_en = 4'b0101;
    @(negedge clk);
    check(clk_gate == 4'b0101, "R10 wait 0101", clk_gate, 5);
    periph_en = 4'b1010;
    @(negedge clk);
    check(clk_gate == 4'b1010, "R10 wait 1010", clk_gate, 10);
    wait_mode = 0;
    @(negedge clk);

    // R11 reset mid-stop
    enter_stop();
    rst = 1;
    @(negedge clk);
    rst = 0;
    check(stop_active == 0 && osc_en == 1 && wake_valid == 0, "R11 reset in stop", stop_active, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule